// File: doc/BRIEF.md
# Period-Capture Frequency Multiplier Timer

The block measures the period of a slow external signal and turns it into a faster internal clock. A wide free-running counter is sampled on a chosen edge of the synchronised input. The difference from the previous sample becomes the measured period.

The period is divided by 32, 64, 128 or 256 with a right shift and becomes the reload value of a down-counter. Each time the down-counter runs out it emits a one-cycle tick and starts again. A multiplier counter advances on every tick, so it moves a fixed number of steps per input period whatever the input frequency is.

Every capture also raises a pulse that neighbouring timers can use to clear their counters. A compare pulse marks the tick on which the multiplier counter reaches a programmed value.

Top module: `period_mult_timer`

## Requirements
- R1: While reset is held low, and right after it is released, `capture`, `cap_stb`, `clr_out`, `tick`, `mul_cnt` and `cmp_hit` are all zero.
- R2: `ext_in` passes through two synchronising flops. An input edge set up before clock edge k is captured at edge k+2, so `cap_stb` is high in the cycle that follows edge k+2.
- R3: `edge_sel` chooses the capture edge: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. With 2'b00 no capture happens and `capture` keeps its value.
- R4: On each capture, `capture` takes the number of clock cycles since the previous capture. This is the difference of free-running counter samples, modulo 2^CW.
- R5: `clr_out` is high for exactly the cycles in which `cap_stb` is high, one cycle per capture.
- R6: The reload value is `capture >> (5 + div_sel)`. It saturates to all ones when the result does not fit in RW bits, and it is forced to 1 when the result is zero. Consecutive ticks are spaced by exactly that many cycles.
- R7: A change of the reload value, whether from a new capture or from a new `div_sel`, takes effect at the next underflow. The interval already in progress finishes with the old value.
- R8: No tick occurs before the first capture after reset. The first tick comes in the cycle after that capture.
- R9: `mul_cnt` rises by one, modulo 2^TW, in the cycle after each tick and holds its value otherwise.
- R10: `cmp_hit` is a one-cycle pulse, high exactly in the cycle in which `mul_cnt` has just stepped to `cmp_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 1 | Asynchronous external input whose period is measured |
| edge_sel | input | 2 | Capture edge: 01 rising, 10 falling, 11 both, 00 none |
| div_sel | input | 2 | Divider: 0 /32, 1 /64, 2 /128, 3 /256 |
| cmp_val | input | TW | Compare value for the multiplier counter |
| capture | output | CW | Last measured period in clock cycles |
| cap_stb | output | 1 | One-cycle pulse after each capture |
| clr_out | output | 1 | Clear pulse for external timer counters |
| tick | output | 1 | Underflow tick of the reload counter |
| mul_cnt | output | TW | Multiplier counter advanced by ticks |
| cmp_hit | output | 1 | Pulse when `mul_cnt` steps to `cmp_val` |

## Verification
A fault in the synchroniser or the edge logic shows up on `cap_stb` within three cycles of an input edge, either as a missing, extra or late pulse. A wrong period difference shows on `capture` at the second capture. A bad shift, saturation or zero guard shows in the spacing of `tick`, at the latest two input periods plus one old reload interval after a change. Errors in reload timing, counting or comparing show on the tick that follows the change, or on the cycle after it.

// File: rtl/period_mult_timer.sv
module period_mult_timer #(
  parameter int CW = 32,
  parameter int RW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_in,
  input  logic [1:0]    edge_sel,
  input  logic [1:0]    div_sel,
  input  logic [TW-1:0] cmp_val,
  output logic [CW-1:0] capture,
  output logic          cap_stb,
  output logic          clr_out,
  output logic          tick,
  output logic [TW-1:0] mul_cnt,
  output logic          cmp_hit
);
  localparam int MIN_SHIFT = 5;

  logic [2:0]    sync_q;
  logic [CW-1:0] free_q, last_q, cap_q;
  logic          stb_q, run_q, hit_q;
  logic [RW-1:0] down_q, reload;
  logic [TW-1:0] mul_q;
  logic [CW-1:0] shifted;

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire cap_now = (edge_sel[0] & rise) | (edge_sel[1] & fall);

  assign shifted = cap_q >> (MIN_SHIFT + int'(div_sel));

  always_comb begin
    if (|(shifted >> RW))         reload = '1;
    else if (shifted[RW-1:0] == '0) reload = RW'(1);
    else                          reload = shifted[RW-1:0];
  end

  assign tick = run_q && (down_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      free_q <= '0;
      last_q <= '0;
      cap_q  <= '0;
      stb_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_in};
      free_q <= free_q + CW'(1);
      stb_q  <= cap_now;
      if (cap_now) begin
        cap_q  <= free_q - last_q;
        last_q <= free_q;
        run_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      down_q <= '0;
      mul_q  <= '0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= tick && ((mul_q + TW'(1)) == cmp_val);
      if (tick) begin
        down_q <= reload - RW'(1);
        mul_q  <= mul_q + TW'(1);
      end else if (run_q) begin
        down_q <= down_q - RW'(1);
      end
    end
  end

  assign capture = cap_q;
  assign cap_stb = stb_q;
  assign clr_out = stb_q;
  assign mul_cnt = mul_q;
  assign cmp_hit = hit_q;
endmodule

// File: rtl/period_mult_timer_checker.sv
module period_mult_timer_checker #(
  parameter int CW = 32,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    edge_sel,
  input logic [TW-1:0] cmp_val,
  input logic [CW-1:0] capture,
  input logic          cap_stb,
  input logic          tick,
  input logic [TW-1:0] mul_cnt,
  input logic          cmp_hit
);
  logic seen_cap;
  always_ff @(posedge clk) begin
    if (!rst_n)       seen_cap <= 1'b0;
    else if (cap_stb) seen_cap <= 1'b1;
  end

  a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_cap && !cap_stb) |-> !tick);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> mul_cnt == $past(mul_cnt) + TW'(1));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mul_cnt));

  a_r10_hit_match: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |-> (mul_cnt == $past(cmp_val)));

  a_r4_capture_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |-> $stable(capture));

  a_r3_none_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |=> !cap_stb);
endmodule

bind period_mult_timer period_mult_timer_checker #(.CW(CW), .TW(TW)) u_checker (.*);

// File: tb/period_mult_timer_bench.sv
module period_mult_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;
  localparam int RW = 8;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_in = 1'b0;
  logic [1:0]    edge_sel = 2'b01;
  logic [1:0]    div_sel = 2'b00;
  logic [TW-1:0] cmp_val = TW'(100);
  logic [CW-1:0] capture;
  logic          cap_stb, clr_out, tick, cmp_hit;
  logic [TW-1:0] mul_cnt;

  period_mult_timer #(.CW(CW), .RW(RW), .TW(TW)) u_period_mult_timer (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .edge_sel(edge_sel),
    .div_sel(div_sel), .cmp_val(cmp_val), .capture(capture),
    .cap_stb(cap_stb), .clr_out(clr_out), .tick(tick),
    .mul_cnt(mul_cnt), .cmp_hit(cmp_hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, failed = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  function automatic int exp_reload(input int per, input int dsel);
    int v;
    v = per >> (5 + dsel);
    if (v > (1 << RW) - 1) v = (1 << RW) - 1;
    if (v == 0) v = 1;
    return v;
  endfunction

  // Square wave generator: period wave_per cycles, high for the first half.
  bit wave_en = 0;
  int wave_per = 100;
  int wcnt = 0;
  always @(negedge clk) begin
    if (wave_en) begin
      ext_in <= (wcnt < wave_per / 2);
      if (wcnt >= wave_per - 1) wcnt <= 0;
      else wcnt <= wcnt + 1;
    end
  end

  // Port monitors
  bit mon_on = 0, prev_tick = 0;
  logic [TW-1:0] prev_mul = '0;
  int cap_cnt = 0, tick_cnt = 0, wraps = 0, hits = 0;
  int r5_err = 0, r9_err = 0, r10_err = 0;
  logic [CW-1:0] last_cap = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_stb) begin cap_cnt++; last_cap = capture; end
      if (tick) tick_cnt++;
      if (cap_stb != clr_out) r5_err++;
      if (cmp_hit) hits++;
      if (mon_on) begin
        if (mul_cnt != prev_mul + TW'(prev_tick)) r9_err++;
        if (prev_tick && prev_mul == '1) wraps++;
        if (cmp_hit && mul_cnt != cmp_val) r10_err++;
        if (!cmp_hit && mul_cnt != prev_mul && mul_cnt == cmp_val) r10_err++;
      end
      prev_mul = mul_cnt;
      prev_tick = tick;
      mon_on = 1;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap_to_tick(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick);
  endtask

  task automatic sync_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  task automatic run_trial(input int per, input int dsel, input string tag);
    int g, c0;
    wave_per = per;
    div_sel = 2'(dsel);
    wait_cycles(3 * per + 300);
    chk(last_cap == CW'(per), {tag, " R4 capture"}, last_cap, per);
    sync_tick();
    gap_to_tick(g);
    chk(g == exp_reload(per, dsel), {tag, " R6 tick spacing"}, g, exp_reload(per, dsel));
    c0 = cap_cnt;
    wait_cycles(2 * per);
    chk(cap_cnt - c0 == 2, {tag, " R3 one capture per period"}, cap_cnt - c0, 2);
  endtask

  initial begin
    int g, c0;
    logic [CW-1:0] held;
    void'($urandom(32'd2024));
    wait_cycles(3);
    // R1: reset state
    chk({capture, cap_stb, clr_out, tick, mul_cnt, cmp_hit} == '0, "R1 reset outputs", capture, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk({capture, cap_stb, clr_out, tick, mul_cnt, cmp_hit} == '0, "R1 after release", mul_cnt, 0);
    wait_cycles(50);
    chk(tick_cnt == 0, "R8 no tick before capture", tick_cnt, 0);

    // R2: synchroniser latency
    ext_in = 1'b1;
    @(negedge clk); chk(cap_stb == 0, "R2 latency cycle 1", cap_stb, 0);
    @(negedge clk); chk(cap_stb == 0, "R2 latency cycle 2", cap_stb, 0);
    @(negedge clk); chk(cap_stb == 1, "R2 latency cycle 3", cap_stb, 1);
    chk(clr_out == 1, "R5 clear with capture", clr_out, 1);
    chk(tick == 1, "R8 first tick after capture", tick, 1);

    // Directed corner cases
    wave_en = 1;
    run_trial(2000, 0, "directed");
    run_trial(20, 0, "zero-forced-to-1");
    run_trial(9000, 0, "saturating");

    // R7: div change takes effect at next underflow
    wave_per = 2000; div_sel = 2'd0;
    wait_cycles(3 * 2000 + 300);
    sync_tick();
    @(negedge clk) div_sel = 2'd1;
    g = 1;
    while (!tick) begin @(negedge clk); g++; end
    chk(g == 62, "R7 interval in progress keeps old value", g, 62);
    gap_to_tick(g);
    chk(g == 31, "R7 new value after underflow", g, 31);

    // Random trials
    for (int i = 0; i < 6; i++) begin
      int per, dsel;
      per = 64 + int'($urandom % 3000);
      dsel = int'($urandom % 4);
      run_trial(per, dsel, "random");
    end

    // R3: falling edge
    edge_sel = 2'b10;
    run_trial(1000, 2, "falling");
    // R3: both edges, even period gives half-period captures
    edge_sel = 2'b11;
    wave_per = 800;
    wait_cycles(3 * 800 + 300);
    chk(last_cap == CW'(400), "R3 both edges half period", last_cap, 400);
    c0 = cap_cnt;
    wait_cycles(1600);
    chk(cap_cnt - c0 == 4, "R3 both edges count", cap_cnt - c0, 4);
    // R3: none
    edge_sel = 2'b00;
    wait_cycles(5);
    held = capture;
    c0 = cap_cnt;
    wait_cycles(2400);
    chk(cap_cnt == c0, "R3 no capture when disabled", cap_cnt - c0, 0);
    chk(capture == held, "R3 capture held when disabled", capture, held);

    chk(r5_err == 0, "R5 clr_out tracks cap_stb", r5_err, 0);
    chk(r9_err == 0, "R9 counter steps", r9_err, 0);
    chk(wraps > 0, "R9 counter wrap seen", wraps, 1);
    chk(r10_err == 0, "R10 compare pulse placement", r10_err, 0);
    chk(hits > 0, "R10 compare pulse seen", hits, 1);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule